// File: doc/BRIEF.md
# Open-Drain Display Control Pin Controller

This block gives software and a hardware I2C engine shared access to three clock/data pin pairs of a display control bus. Each of the six lines has an output-value bit, a drive-enable bit, a synchronized read-back bit and a software-ownership bit. The lines are wired open-drain. Software keeps the output value at zero, so an enabled pad can only pull the line low. A disabled pad leaves the line floating, and the external pull-up brings it high. Software can bit-bang I2C by toggling enables, either directly or through a line-level port that turns a written logical level into the matching enable.

A line whose ownership bit is clear belongs to the hardware engine. A select field routes one pin pair to the engine, or parks the engine on no pair. An engine soft-reset bit releases the routed pins and idles the engine inputs high. This lets software park the engine before it bit-bangs, without the engine holding any line low.

Lines are numbered so that line 2p is the clock of pair p and line 2p+1 is its data. Registers are 32 bits wide and are addressed by word index.

Top module: `ddc_pin_ctrl`

## Requirements
- R1: After reset, every register reads 0, `pad_oe` and `pad_out` are 0, `eng_soft_rst` is 0, and both engine inputs read 1.
- R2: A write changes only the byte lanes whose `reg_be` bit is set. Byte 0 holds the line bits and the engine select (bits 1:0 at address 4). Byte 1 holds the engine soft-reset bit (bit 8 at address 4).
- R3: For a line whose ownership bit (address 3) is 1, `pad_oe` equals its drive-enable bit (address 1) and `pad_out` equals its output-value bit (address 0).
- R4: A write to the line-level port (address 5) applies only to lines whose select bit `wdata[8+i]` is set and byte-enabled, and whose level bit `wdata[i]` is also byte-enabled. For each such line, level 0 sets the drive enable and level 1 clears it. Every other line keeps its drive enable.
- R5: The read-back register (address 2) shows `pad_in` after exactly two clock edges, not after one.
- R6: Writes to the read-back register have no effect on what it returns.
- R7: For a line whose ownership bit is 0, `pad_out` is 0. `pad_oe` follows the engine's low-drive input for that line (`eng_scl_low` for clocks, `eng_sda_low` for data) when the select field equals pair index + 1 and soft reset is 0.
- R8: An unowned line has `pad_oe` = 0 when the select is 0 (parked), when another pair is selected, or when engine soft reset is 1.
- R9: `eng_scl_in` and `eng_sda_in` carry the read-back bits of the selected pair. They are 1 when the engine is parked or in soft reset.
- R10: Addresses 6 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_be | input | 4 | Byte enables for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pad_in | input | 6 | Line levels seen at the pads |
| pad_out | output | 6 | Pad output values |
| pad_oe | output | 6 | Pad drive enables |
| eng_scl_low | input | 1 | Engine wants clock pulled low |
| eng_sda_low | input | 1 | Engine wants data pulled low |
| eng_scl_in | output | 1 | Clock level presented to the engine |
| eng_sda_in | output | 1 | Data level presented to the engine |
| eng_soft_rst | output | 1 | Engine soft-reset control |

## Verification
The bench targets the hand-over between software and engine ownership of a line. A mux keyed to the wrong bit would leave the engine driving a software-owned line, or would leave the pad floating when the engine asks for a low. It checks that parking and soft reset both release the pins; a design that checks only the select would hold the bus low during soft reset. Partial byte-enable writes and line-level writes with a masked select byte must leave the other fields and lines alone; a design that ignores the lanes would clear the soft-reset bit or wrongly change enables. The read-back latency is sampled one edge early to catch a missing synchronizer stage.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int DW       = 32;
  localparam int AW       = 3;
  localparam int BW       = DW / 8;
  localparam int SRST_BIT = 8;   // engine soft-reset bit at the engine register
  localparam int LSEL_LSB = 8;   // line-select field at the line-level port

  typedef enum logic [AW-1:0] {
    A_OUTVAL = 3'd0,
    A_DRVEN  = 3'd1,
    A_SAMPLE = 3'd2,
    A_OWN    = 3'd3,
    A_ENG    = 3'd4,
    A_LINE   = 3'd5
  } ddc_addr_e;
endpackage

// File: rtl/ddc_rst_sync.sv
module ddc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/ddc_in_sync.sv
module ddc_in_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/ddc_regs.sv
module ddc_regs
  import ddc_pkg::*;
#(
  parameter int LINES = 6,
  parameter int SELW  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [BW-1:0]    be,
  input  logic [DW-1:0]    wdata,
  input  logic [LINES-1:0] smp,
  output logic [DW-1:0]    rdata,
  output logic [LINES-1:0] out_q,
  output logic [LINES-1:0] drv_q,
  output logic [LINES-1:0] own_q,
  output logic [SELW-1:0]  sel_q,
  output logic             srst_q
);
  logic [DW-1:0]    bmask;
  logic [DW-1:0]    wmerge_out, wmerge_drv, wmerge_own, wmerge_eng;
  logic [LINES-1:0] out_d, drv_d, own_d;
  logic [SELW-1:0]  sel_d;
  logic             srst_d;
  logic             out_en, drv_en, own_en, eng_en;

  always_comb begin
    for (int i = 0; i < DW; i++) bmask[i] = be[i/8];
  end

  always_comb begin
    wmerge_out = ({{(DW-LINES){1'b0}}, out_q} & ~bmask) | (wdata & bmask);
    wmerge_drv = ({{(DW-LINES){1'b0}}, drv_q} & ~bmask) | (wdata & bmask);
    wmerge_own = ({{(DW-LINES){1'b0}}, own_q} & ~bmask) | (wdata & bmask);
    wmerge_eng = '0;
    wmerge_eng[SELW-1:0] = sel_q;
    wmerge_eng[SRST_BIT] = srst_q;
    wmerge_eng = (wmerge_eng & ~bmask) | (wdata & bmask);
  end

  // next state
  always_comb begin
    out_en = 1'b0;
    drv_en = 1'b0;
    own_en = 1'b0;
    eng_en = 1'b0;
    out_d  = out_q;
    drv_d  = drv_q;
    own_d  = own_q;
    sel_d  = sel_q;
    srst_d = srst_q;
    if (we) begin
      case (addr)
        A_OUTVAL: begin out_en = 1'b1; out_d = wmerge_out[LINES-1:0]; end
        A_DRVEN:  begin drv_en = 1'b1; drv_d = wmerge_drv[LINES-1:0]; end
        A_OWN:    begin own_en = 1'b1; own_d = wmerge_own[LINES-1:0]; end
        A_ENG: begin
          eng_en = 1'b1;
          sel_d  = wmerge_eng[SELW-1:0];
          srst_d = wmerge_eng[SRST_BIT];
        end
        A_LINE: begin
          drv_en = 1'b1;
          for (int i = 0; i < LINES; i++) begin
            if (wdata[LSEL_LSB+i] && bmask[LSEL_LSB+i] && bmask[i])
              drv_d[i] = ~wdata[i];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      drv_q  <= '0;
      own_q  <= '0;
      sel_q  <= '0;
      srst_q <= 1'b0;
    end else begin
      if (out_en) out_q <= out_d;
      if (drv_en) drv_q <= drv_d;
      if (own_en) own_q <= own_d;
      if (eng_en) begin
        sel_q  <= sel_d;
        srst_q <= srst_d;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_OUTVAL: rdata[LINES-1:0] = out_q;
      A_DRVEN:  rdata[LINES-1:0] = drv_q;
      A_SAMPLE: rdata[LINES-1:0] = smp;
      A_OWN:    rdata[LINES-1:0] = own_q;
      A_ENG: begin
        rdata[SELW-1:0] = sel_q;
        rdata[SRST_BIT] = srst_q;
      end
      default: rdata = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^{wmerge_out[DW-1:LINES], wmerge_drv[DW-1:LINES],
                          wmerge_own[DW-1:LINES], wmerge_eng};
endmodule

// File: rtl/ddc_pad_mux.sv
module ddc_pad_mux #(
  parameter int PAIRS = 3,
  parameter int SELW  = 2
) (
  input  logic [2*PAIRS-1:0] out_q,
  input  logic [2*PAIRS-1:0] drv_q,
  input  logic [2*PAIRS-1:0] own_q,
  input  logic [2*PAIRS-1:0] smp,
  input  logic [SELW-1:0]    sel,
  input  logic               srst,
  input  logic               eng_scl_low,
  input  logic               eng_sda_low,
  output logic [2*PAIRS-1:0] pad_out,
  output logic [2*PAIRS-1:0] pad_oe,
  output logic               eng_scl_in,
  output logic               eng_sda_in
);
  logic [PAIRS-1:0] hit;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign hit[p] = !srst && (sel == SELW'(p + 1));

    // clock line of the pair
    assign pad_oe[2*p]    = own_q[2*p]   ? drv_q[2*p]   : (hit[p] && eng_scl_low);
    assign pad_out[2*p]   = own_q[2*p]   & out_q[2*p];
    // data line of the pair
    assign pad_oe[2*p+1]  = own_q[2*p+1] ? drv_q[2*p+1] : (hit[p] && eng_sda_low);
    assign pad_out[2*p+1] = own_q[2*p+1] & out_q[2*p+1];
  end

  always_comb begin
    eng_scl_in = 1'b1;
    eng_sda_in = 1'b1;
    for (int p = 0; p < PAIRS; p++) begin
      if (hit[p]) begin
        eng_scl_in = smp[2*p];
        eng_sda_in = smp[2*p+1];
      end
    end
  end
endmodule

// File: rtl/ddc_pin_ctrl.sv
module ddc_pin_ctrl
  import ddc_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  localparam int LINES = 2 * NUM_PAIRS,
  localparam int SELW  = $clog2(NUM_PAIRS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [BW-1:0]    reg_be,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [LINES-1:0] pad_in,
  output logic [LINES-1:0] pad_out,
  output logic [LINES-1:0] pad_oe,
  input  logic             eng_scl_low,
  input  logic             eng_sda_low,
  output logic             eng_scl_in,
  output logic             eng_sda_in,
  output logic             eng_soft_rst
);
  logic             rst_n_sync;
  logic [LINES-1:0] smp_q, out_q, drv_q, own_q;
  logic [SELW-1:0]  eng_sel_q;
  logic             eng_srst_q;

  ddc_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  ddc_in_sync #(.W(LINES)) u_sync (
    .clk(clk), .rst_n(rst_n_sync), .d(pad_in), .q(smp_q)
  );

  ddc_regs #(.LINES(LINES), .SELW(SELW)) u_regs (
    .clk(clk), .rst_n(rst_n_sync), .we(reg_we), .addr(reg_addr),
    .be(reg_be), .wdata(reg_wdata), .smp(smp_q), .rdata(reg_rdata),
    .out_q(out_q), .drv_q(drv_q), .own_q(own_q),
    .sel_q(eng_sel_q), .srst_q(eng_srst_q)
  );

  ddc_pad_mux #(.PAIRS(NUM_PAIRS), .SELW(SELW)) u_mux (
    .out_q(out_q), .drv_q(drv_q), .own_q(own_q), .smp(smp_q),
    .sel(eng_sel_q), .srst(eng_srst_q),
    .eng_scl_low(eng_scl_low), .eng_sda_low(eng_sda_low),
    .pad_out(pad_out), .pad_oe(pad_oe),
    .eng_scl_in(eng_scl_in), .eng_sda_in(eng_sda_in)
  );

  assign eng_soft_rst = eng_srst_q;
endmodule

// File: rtl/ddc_pin_ctrl_chk.sv
module ddc_pin_ctrl_chk
  import ddc_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  localparam int LINES = 2 * NUM_PAIRS,
  localparam int SELW  = $clog2(NUM_PAIRS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [AW-1:0]    reg_addr,
  input logic [BW-1:0]    reg_be,
  input logic [DW-1:0]    reg_wdata,
  input logic [LINES-1:0] pad_in,
  input logic [LINES-1:0] pad_oe,
  input logic             eng_soft_rst,
  input logic [LINES-1:0] own,
  input logic [LINES-1:0] drv,
  input logic [LINES-1:0] smp,
  input logic [SELW-1:0]  eng_sel
);
  logic [1:0] since_rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst_q <= '0;
    else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
  end

  // R2
  soft_rst_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_ENG && !reg_be[1]) |=> $stable(eng_soft_rst));

  // R5
  sample_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst_q == 2'd3) |-> (smp == $past(pad_in, 2)));

  for (genvar i = 0; i < LINES; i++) begin : g_line
    // R4
    line_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_LINE && reg_be[0] && reg_be[1] && reg_wdata[LSEL_LSB+i])
        |=> (drv[i] == !$past(reg_wdata[i])));

    // R8
    engine_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!own[i] && pad_oe[i]) |-> (!eng_soft_rst && eng_sel == SELW'(i/2 + 1)));

    // R3
    sw_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (own[i] && $rose(pad_oe[i])) |-> drv[i]);
  end
endmodule

bind ddc_pin_ctrl ddc_pin_ctrl_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_be(reg_be), .reg_wdata(reg_wdata), .pad_in(pad_in), .pad_oe(pad_oe),
  .eng_soft_rst(eng_soft_rst), .own(own_q), .drv(drv_q), .smp(smp_q),
  .eng_sel(eng_sel_q)
);

// File: tb/test_ddc_pin_ctrl.sv
module test_ddc_pin_ctrl;
  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [5:0]  pad_in, pad_out, pad_oe;
  logic        eng_scl_low, eng_sda_low, eng_scl_in, eng_sda_in, eng_soft_rst;

  int checks = 0;
  int errors = 0;

  ddc_pin_ctrl i_ddc_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .eng_scl_low(eng_scl_low), .eng_sda_low(eng_sda_low),
    .eng_scl_in(eng_scl_in), .eng_sda_in(eng_sda_in),
    .eng_soft_rst(eng_soft_rst)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; reg_be = '0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R1 reg reset", v, 0);
    end
    check("R1 pad_oe", {26'd0, pad_oe}, 0);
    check("R1 pad_out", {26'd0, pad_out}, 0);
    check("R1 soft rst", {31'd0, eng_soft_rst}, 0);
    check("R1 eng inputs", {30'd0, eng_scl_in, eng_sda_in}, 32'h3);
  endtask

  task automatic t_byte_lanes;
    logic [31:0] v;
    wr(3'd4, 32'h0000_0102, 4'b0001);
    rd(3'd4, v);
    check("R2 byte0 only", v, 32'h2);
    wr(3'd4, 32'h0000_0100, 4'b0010);
    rd(3'd4, v);
    check("R2 byte1 only", v, 32'h102);
    check("R2 soft rst pin", {31'd0, eng_soft_rst}, 1);
    wr(3'd0, 32'h0000_003F, 4'b0000);
    rd(3'd0, v);
    check("R2 no lanes", v, 0);
    wr(3'd4, 32'h0, 4'b0011);
  endtask

  task automatic t_sw_drive;
    wr(3'd3, 32'h3F, 4'b0001);
    wr(3'd1, 32'h05, 4'b0001);
    check("R3 oe follows enable", {26'd0, pad_oe}, 32'h05);
    check("R3 out zero", {26'd0, pad_out}, 0);
    wr(3'd0, 32'h02, 4'b0001);
    check("R3 out follows value", {26'd0, pad_out}, 32'h02);
    wr(3'd0, 32'h00, 4'b0001);
  endtask

  task automatic t_line_level;
    logic [31:0] v;
    wr(3'd5, 32'h0000_0A00, 4'b0011);
    rd(3'd1, v);
    check("R4 level0 sets enable", v, 32'h0F);
    wr(3'd5, 32'h0000_0101, 4'b0011);
    rd(3'd1, v);
    check("R4 level1 clears enable", v, 32'h0E);
    wr(3'd5, 32'h0000_3F00, 4'b0001);
    rd(3'd1, v);
    check("R4 masked select byte", v, 32'h0E);
    check("R4 pads", {26'd0, pad_oe}, 32'h0E);
  endtask

  task automatic t_readback;
    logic [31:0] v;
    @(negedge clk);
    pad_in = 6'h00;
    repeat (3) @(negedge clk);
    pad_in = 6'h2D;
    @(negedge clk);
    rd(3'd2, v);
    check("R5 one edge", v, 0);
    @(negedge clk);
    rd(3'd2, v);
    check("R5 two edges", v, 32'h2D);
  endtask

  task automatic t_sample_ro;
    logic [31:0] v;
    wr(3'd2, 32'h0, 4'b1111);
    rd(3'd2, v);
    check("R6 sample write ignored", v, 32'h2D);
  endtask

  task automatic t_engine_route;
    wr(3'd3, 32'h00, 4'b0001);
    wr(3'd4, 32'h02, 4'b0001);
    eng_scl_low = 1'b1; eng_sda_low = 1'b0;
    #1;
    check("R7 engine clock", {26'd0, pad_oe}, 32'h04);
    eng_sda_low = 1'b1;
    #1;
    check("R7 engine both", {26'd0, pad_oe}, 32'h0C);
    wr(3'd3, 32'h04, 4'b0001);
    wr(3'd1, 32'h00, 4'b0001);
    check("R7 mixed ownership", {26'd0, pad_oe}, 32'h08);
    check("R7 out zero", {26'd0, pad_out}, 0);
  endtask

  task automatic t_release;
    wr(3'd3, 32'h00, 4'b0001);
    wr(3'd4, 32'h00, 4'b0001);
    check("R8 parked", {26'd0, pad_oe}, 0);
    wr(3'd4, 32'h03, 4'b0001);
    check("R8 pair2 only", {26'd0, pad_oe}, 32'h30);
    wr(3'd4, 32'h103, 4'b0011);
    check("R8 soft reset", {26'd0, pad_oe}, 0);
  endtask

  task automatic t_eng_inputs;
    wr(3'd4, 32'h03, 4'b0011);
    check("R9 pair2", {30'd0, eng_scl_in, eng_sda_in}, 32'h1);
    wr(3'd4, 32'h01, 4'b0011);
    check("R9 pair0", {30'd0, eng_scl_in, eng_sda_in}, 32'h2);
    wr(3'd4, 32'h101, 4'b0011);
    check("R9 soft reset idles", {30'd0, eng_scl_in, eng_sda_in}, 32'h3);
    wr(3'd4, 32'h00, 4'b0011);
    check("R9 parked idles", {30'd0, eng_scl_in, eng_sda_in}, 32'h3);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(3'd3, 32'h15, 4'b0001);
    wr(3'd6, 32'hFFFF_FFFF, 4'b1111);
    wr(3'd7, 32'hFFFF_FFFF, 4'b1111);
    rd(3'd6, v);
    check("R10 read 6", v, 0);
    rd(3'd7, v);
    check("R10 read 7", v, 0);
    rd(3'd3, v);
    check("R10 own intact", v, 32'h15);
    rd(3'd4, v);
    check("R10 engine intact", v, 0);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_be = '0; reg_wdata = '0;
    pad_in = 6'h3F; eng_scl_low = 1'b0; eng_sda_low = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_byte_lanes();
    t_sw_drive();
    t_line_level();
    t_readback();
    t_sample_ro();
    t_engine_route();
    t_release();
    t_eng_inputs();
    t_unmapped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule